// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block guards a programmable clock generator against a system that hangs after being overclocked. Software programs a timeout in whole seconds and sets an enable bit. From then on, an externally supplied one-second tick counts the timeout down. Software services the watchdog by rewriting the timeout register, which reloads the counter.

If the count runs out, three things happen. A sticky status flag is set. The frequency-select output switches from the hardware selection to a stored safe code. The clock-source select is forced back to the hardware path. A system reset pulse of fixed length is also issued. The override stays in force until software clears the status flag.

The control word has this layout: bits [3:0] hold the safe frequency code, bit 4 is the enable, bit 5 is the status (write 0 to clear), bit 6 is unused, and bit 7 selects the register-programmed divider path.

Top module: `oc_watchdog`

## Requirements
- R1: After reset, `status_o`=0, `sys_rst_o`=0, `fs_o` equals `hw_fs_i`, `prog_sel_o`=0, and the timeout register holds 16.
- R2: Setting the enable bit (control bit 4) from 0 to 1 with the default timeout makes the status set on the 16th tick after enabling, and not on the 15th.
- R3: With a timeout of N≥1, expiry occurs on the Nth tick after the counter is armed. A timeout of 0 expires on the first tick.
- R4: A write to the timeout register while the counter runs reloads the counter with the written value, so that many further ticks are needed.
- R5: On expiry, `status_o` becomes 1 in the clock after the expiring tick is sampled. It stays 1 until a control write with bit 5 equal to 0. A control write with bit 5 equal to 1 never sets it.
- R6: While `status_o`=1, `fs_o` equals the safe code (control bits [3:0]). Otherwise `fs_o` equals `hw_fs_i`.
- R7: `sys_rst_o` is high for exactly 16 clocks, starting in the clock after the expiring tick is sampled.
- R8: Clearing the enable bit stops the counter: no expiry occurs while disabled, and `status_o` keeps its value.
- R9: `prog_sel_o` follows control bit 7 while `status_o`=0 and is 0 while `status_o`=1.
- R10: A control write with the enable bit set while already enabled does not reload the counter. After an expiry, further ticks cause no new expiry and no new reset pulse until the enable bit goes 0 then 1.
- R11: A timeout-register write in the same clock as a tick takes priority: the counter reloads and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second tick, one clock wide |
| cnt_we_i | input | 1 | Timeout register write strobe (kick) |
| cnt_wdata_i | input | CNT_W | Timeout value in seconds |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control word (safe code, enable, status, path select) |
| hw_fs_i | input | FS_W | Hardware frequency selection |
| status_o | output | 1 | Sticky timeout status |
| fs_o | output | FS_W | Effective frequency select |
| prog_sel_o | output | 1 | Register-programmed divider path select |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest situations to reach are the collisions. One is a kick landing in the same clock as a tick. Another is a redundant enable write landing mid-count. Reaching these needs exact control of which clock each strobe occupies. The bench drives the tick and both write strobes from one negedge, so each coincidence is placed deliberately. It then counts the remaining ticks to expiry to show whether the reload took effect. The no-second-pulse case is reached by letting a pulse finish and then applying extra ticks with the enable still set.

// File: rtl/oc_wdt_pkg.sv
package oc_wdt_pkg;
  localparam int CTL_W    = 8;
  localparam int FS_W     = 4;
  localparam int EN_BIT   = FS_W;
  localparam int ST_BIT   = FS_W + 1;
  localparam int PSEL_BIT = CTL_W - 1;

  typedef struct packed {
    logic            psel;
    logic            en;
    logic [FS_W-1:0] safe;
  } ctl_t;
endpackage

// File: rtl/oc_wdt_regs.sv
module oc_wdt_regs
  import oc_wdt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TMO_RST = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             expire_i,
  output logic [CNT_W-1:0] tmo_o,
  output ctl_t             ctl_o,
  output logic             status_o,
  output logic             arm_o,
  output logic             disarm_o
);
  logic [CNT_W-1:0] tmo_q;
  ctl_t             ctl_q;
  logic             status_q;

  assign arm_o    = ctl_we_i &  ctl_wdata_i[EN_BIT] & ~ctl_q.en;
  assign disarm_o = ctl_we_i & ~ctl_wdata_i[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q    <= CNT_W'(TMO_RST);
      ctl_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (cnt_we_i) tmo_q <= cnt_wdata_i;
      if (ctl_we_i) begin
        ctl_q.psel <= ctl_wdata_i[PSEL_BIT];
        ctl_q.en   <= ctl_wdata_i[EN_BIT];
        ctl_q.safe <= ctl_wdata_i[FS_W-1:0];
      end
      // set beats clear; writing 1 never sets
      if (expire_i)                             status_q <= 1'b1;
      else if (ctl_we_i && !ctl_wdata_i[ST_BIT]) status_q <= 1'b0;
    end
  end

  assign tmo_o    = tmo_q;
  assign ctl_o    = ctl_q;
  assign status_o = status_q;

  assert_status_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !(ctl_we_i && !ctl_wdata_i[ST_BIT])) |=> status_q);
  assert_status_no_sw_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_q && !expire_i) |=> !status_q);
endmodule

// File: rtl/oc_wdt_sec_cnt.sv
module oc_wdt_sec_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic             disarm_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             step;

  // writes and enable changes win over a coincident tick
  assign step     = run_q & tick_i & ~load_i & ~arm_i & ~disarm_i;
  assign expire_o = step & (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (arm_i)         run_q <= 1'b1;
      else if (disarm_i) run_q <= 1'b0;
      else if (expire_o) run_q <= 1'b0;

      if (load_i)        cnt_q <= load_val_i;
      else if (arm_i)    cnt_q <= tmo_i;
      else if (step && !expire_o) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_expire_stops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !run_q);
  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !arm_i) |=> $stable(cnt_q));
  assert_disarm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disarm_i && !arm_i) |=> !run_q);
endmodule

// File: rtl/oc_wdt_rst_pulse.sv
module oc_wdt_rst_pulse #(
  parameter int RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);
  localparam int RW = $clog2(RST_CYC + 1);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= RW'(RST_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - RW'(1);
  end

  assign pulse_o = (cnt_q != '0);

  assert_pulse_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pulse_o);
  assert_pulse_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RW'(RST_CYC));
endmodule

// File: rtl/oc_watchdog.sv
module oc_watchdog
  import oc_wdt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TMO_RST = 16,
  parameter int RST_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic [FS_W-1:0]  hw_fs_i,
  output logic             status_o,
  output logic [FS_W-1:0]  fs_o,
  output logic             prog_sel_o,
  output logic             sys_rst_o
);
  logic [CNT_W-1:0] tmo;
  ctl_t             ctl;
  logic             status, arm, disarm, expire;

  oc_wdt_regs #(.CNT_W(CNT_W), .TMO_RST(TMO_RST)) u_regs (
    .clk_i, .rst_ni, .ctl_we_i, .ctl_wdata_i, .cnt_we_i, .cnt_wdata_i,
    .expire_i(expire), .tmo_o(tmo), .ctl_o(ctl), .status_o(status),
    .arm_o(arm), .disarm_o(disarm)
  );

  oc_wdt_sec_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .arm_i(arm), .disarm_i(disarm),
    .load_i(cnt_we_i), .load_val_i(cnt_wdata_i), .tmo_i(tmo), .expire_o(expire)
  );

  oc_wdt_rst_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk_i, .rst_ni, .start_i(expire), .pulse_o(sys_rst_o)
  );

  assign status_o   = status;
  assign fs_o       = status ? ctl.safe : hw_fs_i;
  assign prog_sel_o = ctl.psel & ~status;

  assert_status_with_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> sys_rst_o);
  assert_override_path_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> !prog_sel_o);
endmodule

// File: tb/oc_watchdog_bench.sv
module oc_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic       clk = 0, rst_ni = 0, tick = 0, cnt_we = 0, ctl_we = 0;
  logic [7:0] cnt_wdata = '0, ctl_wdata = '0;
  logic [3:0] hw_fs = 4'h3;
  logic       status, prog_sel, sys_rst;
  logic [3:0] fs;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_watchdog u_oc_watchdog (
    .clk_i(clk), .rst_ni, .tick_i(tick), .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .hw_fs_i(hw_fs),
    .status_o(status), .fs_o(fs), .prog_sel_o(prog_sel), .sys_rst_o(sys_rst)
  );

  // {timeout, ticks, expected status}
  localparam logic [17:0] VEC [8] = '{
    {8'd3, 9'd2, 1'b0}, {8'd3, 9'd3, 1'b1}, {8'd0, 9'd1, 1'b1}, {8'd1, 9'd1, 1'b1},
    {8'd5, 9'd4, 1'b0}, {8'd5, 9'd5, 1'b1}, {8'd40, 9'd39, 1'b0}, {8'd40, 9'd40, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // ctl word: [7] prog path, [5] status, [4] enable, [3:0] safe code
  task automatic wr_ctl(logic psel, logic st, logic en, logic [3:0] safe);
    @(negedge clk); ctl_we = 1; ctl_wdata = {psel, 1'b0, st, en, safe};
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic wr_cnt(logic [7:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask
  task automatic settle();
    repeat (20) @(negedge clk);
    wr_ctl(0, 0, 0, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 status", status, 0);
    check("R1 sys_rst", sys_rst, 0);
    check("R1 fs", fs, 4'h3);
    check("R1 prog_sel", prog_sel, 0);

    // R2 default timeout 16
    wr_ctl(1, 0, 1, 4'hA);
    check("R9 prog_sel follows", prog_sel, 1);
    ticks(15);
    check("R2 not at 15", status, 0);
    ticks(1);
    check("R2 at 16", status, 1);
    check("R6 safe code", fs, 4'hA);
    check("R9 forced off", prog_sel, 0);
    // R7 pulse length: first sample already in pulse
    begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin
        if (sys_rst) hi++;
        @(negedge clk);
      end
      check("R7 pulse length", hi, 16);
    end
    // R10 no second expiry while still enabled
    ticks(20);
    check("R10 no new pulse", sys_rst, 0);
    // R5 writing 1 keeps; writing 0 clears
    wr_ctl(1, 1, 1, 4'hA);
    check("R5 write1 keeps", status, 1);
    wr_ctl(1, 0, 1, 4'hA);
    check("R5 clear", status, 0);
    check("R6 hw path back", fs, 4'h3);
    settle();

    // table walk (R3)
    foreach (VEC[k]) begin
      wr_cnt(VEC[k][17:10]);
      wr_ctl(0, 0, 1, 4'h5);
      ticks(int'(VEC[k][9:1]));
      check($sformatf("R3 vec%0d", k), status, VEC[k][0]);
      settle();
    end

    // R4 kick
    wr_cnt(8'd4);
    wr_ctl(0, 0, 1, 4'h1);
    ticks(3);
    wr_cnt(8'd4);
    ticks(3);
    check("R4 kick delays", status, 0);
    ticks(1);
    check("R4 expiry after kick", status, 1);
    settle();

    // R8 disable stops
    wr_cnt(8'd2);
    wr_ctl(0, 0, 1, 4'h1);
    ticks(1);
    wr_ctl(0, 0, 0, 4'h1);
    ticks(5);
    check("R8 stopped", status, 0);
    check("R8 no pulse", sys_rst, 0);
    // R8 disable keeps set status
    wr_ctl(0, 0, 1, 4'h1);
    ticks(2);
    check("R8 expired", status, 1);
    wr_ctl(0, 1, 0, 4'h1);
    check("R8 status kept", status, 1);
    settle();

    // R10 redundant enable does not reload
    wr_cnt(8'd3);
    wr_ctl(0, 0, 1, 4'h2);
    ticks(2);
    wr_ctl(0, 0, 1, 4'h2);
    ticks(1);
    check("R10 no reload", status, 1);
    settle();

    // R11 kick coincident with tick
    wr_cnt(8'd2);
    wr_ctl(0, 0, 1, 4'h2);
    ticks(1);
    @(negedge clk); tick = 1; cnt_we = 1; cnt_wdata = 8'd2;
    @(negedge clk); tick = 0; cnt_we = 0;
    ticks(1);
    check("R11 tick dropped", status, 0);
    ticks(1);
    check("R11 expiry", status, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule